// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a page table entry and a physical address for a 386-class paging unit. A request carries the linear address and a write flag. The block samples the paging enable, the write-protect enable, the current privilege level and the virtual-8086 flag together with the request. It first looks in a small direct-mapped translation cache. On a miss it walks two levels of tables in memory through a single 32-bit request/response port.

During the walk the block sets the accessed bit on each level and writes that level back to memory. On write accesses it also sets the dirty bit. It folds the directory permissions into the table entry, fills the cache, and reports the merged entry with a page-fault flag and a 3-bit error code. Splitting accesses that cross a page and taking the exception belong to the surrounding core.

Top module: `page_walker`

## Requirements
- R1: When the cache slot chosen by linear bits [15:12] (default depth 16) holds a valid entry whose tag matches the rest of the page number, the stored entry is returned with `hit_o` high and no memory request.
- R2: On a miss the first memory read is at `cr3_i + 4*lin[31:22]`. A directory word with bit 0 (present) clear ends the walk: the returned entry is 0 and a fault is reported.
- R3: If the directory word has bit 5 (accessed) clear, it is written back to the same address with bit 5 set before the table is read. If bit 5 is already set, there is no write.
- R4: The table word is read at `{dir[31:12],12'h000} + 4*lin[21:12]`. If its bit 0 is clear, the returned entry is 0 and a fault is reported.
- R5: On a write access, bit 6 (dirty) is set in the returned entry. If the table word's bit 5 is clear, the word is written back with bit 5 set (and bit 6 for writes). If bit 5 is already set, nothing is written.
- R6: Bit 1 (writable) and bit 2 (user) of the returned entry are the AND of the directory and table bits. The merged entry fills the cache. `phys_o` is `{entry[31:12], lin[11:0]}`.
- R7: A fault is raised if the entry is not present, or if bit 2 is clear while the effective privilege is above 0, or if the access is a write with write-protect enabled and bit 1 clear. `fault_code_o` is entry bits [2:0].
- R8: The effective privilege is 3 whenever the virtual-8086 flag is set, whatever `cpl_i` holds.
- R9: `flush_i` invalidates every cache slot in one cycle. A stored entry equal to all ones counts as a miss.
- R10: With paging disabled, `phys_o` equals the linear address, the entry is 0, there is no fault and no memory request.
- R11: A request is taken when `req_valid_i` and `req_ready_o` are both high. `done_o` is a one-cycle pulse. A memory request is held until `mem_resp_valid_i` and is never issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_lin_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| cr3_i | input | 32 | Directory base address |
| paging_en_i | input | 1 | Paging enabled |
| wprot_en_i | input | 1 | Write protect enabled |
| cpl_i | input | 2 | Current privilege level |
| v86_i | input | 1 | Virtual-8086 mode |
| flush_i | input | 1 | Invalidate the whole cache |
| mem_req_valid_o | output | 1 | Memory access request |
| mem_req_write_o | output | 1 | Memory access is a write |
| mem_req_addr_o | output | 32 | Memory byte address |
| mem_req_wdata_o | output | 32 | Memory write data |
| mem_resp_valid_i | input | 1 | Memory access complete |
| mem_resp_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | Result valid pulse |
| entry_o | output | 32 | Merged page table entry |
| phys_o | output | 32 | Physical address |
| fault_o | output | 1 | Page fault |
| fault_code_o | output | 3 | Page-fault error code |
| hit_o | output | 1 | Result came from the cache |

## Verification
The bench sets up directory and table words with the accessed bit clear in one case and already set in another. It counts the reads and writes of each access, so a design that skips a write-back, or that writes back an entry whose accessed bit was already set, shows the wrong count or leaves memory wrong. It pairs a read-only directory with a writable table, and a supervisor directory with a user table. A walker that used only the table bits would then miss the write-protect and user faults, and the bench also checks that a virtual-8086 access at privilege 0 still faults. Finally it repeats an address after a flush and after caching an all-ones entry; a design that kept serving either from the cache would show zero memory reads.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int WORD_W  = 32;
    localparam int PAGE_W  = 20;
    localparam int BIT_P   = 0;
    localparam int BIT_RW  = 1;
    localparam int BIT_US  = 2;
    localparam int BIT_ACC = 5;
    localparam int BIT_DRT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RD_DIR,
        ST_WB_DIR,
        ST_RD_TBL,
        ST_WB_TBL
    } walk_st_e;

    typedef struct packed {
        walk_st_e           st;
        logic [WORD_W-1:0]  lin;
        logic               wr;
        logic               wp;
        logic               pg;
        logic [1:0]         cpl;
        logic               v86;
        logic [WORD_W-1:0]  dir;
        logic [WORD_W-1:0]  tbl;
        logic               done;
        logic [WORD_W-1:0]  entry;
        logic [WORD_W-1:0]  phys;
        logic               fault;
        logic [2:0]         code;
        logic               hit;
    } walk_regs_t;

    // Table entry with its permission bits restricted by the directory entry
    function automatic logic [WORD_W-1:0] merge_perm(input logic [WORD_W-1:0] tbl_w,
                                                     input logic [WORD_W-1:0] dir_w);
        logic [WORD_W-1:0] r;
        r         = tbl_w;
        r[BIT_RW] = tbl_w[BIT_RW] & dir_w[BIT_RW];
        r[BIT_US] = tbl_w[BIT_US] & dir_w[BIT_US];
        return r;
    endfunction

endpackage

// File: rtl/pw_tlb.sv
module pw_tlb
    import pw_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic [PAGE_W-1:0]  look_page_i,
    output logic               hit_o,
    output logic [WORD_W-1:0]  hit_entry_o,
    input  logic               fill_i,
    input  logic [PAGE_W-1:0]  fill_page_i,
    input  logic [WORD_W-1:0]  fill_entry_i
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TAG_W = PAGE_W - IDX_W;

    logic [DEPTH-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [WORD_W-1:0] data_q [DEPTH];

    logic [IDX_W-1:0]  look_idx, fill_idx;
    logic [TAG_W-1:0]  look_tag;

    assign look_idx = look_page_i[IDX_W-1:0];
    assign look_tag = look_page_i[PAGE_W-1:IDX_W];
    assign fill_idx = fill_page_i[IDX_W-1:0];

    always_comb begin
        valid_d = valid_q;
        if (fill_i)  valid_d[fill_idx] = 1'b1;
        if (flush_i) valid_d = '0;             // flush wins over a same-cycle fill
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (fill_i) begin
            tag_q[fill_idx]  <= fill_page_i[PAGE_W-1:IDX_W];
            data_q[fill_idx] <= fill_entry_i;
        end
    end

    assign hit_entry_o = data_q[look_idx];
    assign hit_o       = valid_q[look_idx] && (tag_q[look_idx] == look_tag)
                         && (data_q[look_idx] != '1);

    // R9: nothing survives a flush into the following cycle
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> !hit_o);

endmodule

// File: rtl/pw_perm.sv
module pw_perm
    import pw_pkg::*;
(
    input  logic [2:0] low_bits_i,
    input  logic       write_i,
    input  logic       wprot_i,
    input  logic [1:0] cpl_i,
    input  logic       v86_i,
    output logic       fault_o,
    output logic [2:0] code_o
);
    logic [1:0] eff_priv;

    assign eff_priv = v86_i ? 2'd3 : cpl_i;      // R8

    always_comb begin
        fault_o = !low_bits_i[BIT_P]
                | (!low_bits_i[BIT_US] && (eff_priv != 2'd0))
                | (write_i && wprot_i && !low_bits_i[BIT_RW]);
        code_o  = low_bits_i;
    end

    // R8: virtual-8086 accesses to a present supervisor page always fault
    assert_v86_user_R8: assert final (!(v86_i && low_bits_i[BIT_P]
        && !low_bits_i[BIT_US]) || fault_o);

endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
#(
    parameter int TLB_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [WORD_W-1:0]  req_lin_i,
    input  logic               req_write_i,
    input  logic [WORD_W-1:0]  cr3_i,
    input  logic               paging_en_i,
    input  logic               wprot_en_i,
    input  logic [1:0]         cpl_i,
    input  logic               v86_i,
    input  logic               flush_i,
    output logic               mem_req_valid_o,
    output logic               mem_req_write_o,
    output logic [WORD_W-1:0]  mem_req_addr_o,
    output logic [WORD_W-1:0]  mem_req_wdata_o,
    input  logic               mem_resp_valid_i,
    input  logic [WORD_W-1:0]  mem_resp_rdata_i,
    output logic               done_o,
    output logic [WORD_W-1:0]  entry_o,
    output logic [WORD_W-1:0]  phys_o,
    output logic               fault_o,
    output logic [2:0]         fault_code_o,
    output logic               hit_o
);
    walk_regs_t r_d, r_q;

    logic               tlb_hit;
    logic [WORD_W-1:0]  tlb_entry;
    logic               fin_go, fin_bypass, fin_hit, fin_fill;
    logic [WORD_W-1:0]  fin_entry;
    logic               perm_fault;
    logic [2:0]         perm_code;
    logic [WORD_W-1:0]  dirty_mask, acc_mask;
    logic [WORD_W-1:0]  dir_addr, tbl_addr;

    assign dirty_mask = r_q.wr ? (WORD_W'(1) << BIT_DRT) : '0;
    assign acc_mask   = WORD_W'(1) << BIT_ACC;
    assign dir_addr   = cr3_i + {20'd0, r_q.lin[31:22], 2'b00};
    assign tbl_addr   = {r_q.dir[31:12], 12'h000} + {20'd0, r_q.lin[21:12], 2'b00};

    pw_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .look_page_i  (r_q.lin[31:12]),
        .hit_o        (tlb_hit),
        .hit_entry_o  (tlb_entry),
        .fill_i       (fin_fill),
        .fill_page_i  (r_q.lin[31:12]),
        .fill_entry_i (fin_entry)
    );

    pw_perm u_perm (
        .low_bits_i (fin_entry[2:0]),
        .write_i    (r_q.wr),
        .wprot_i    (r_q.wp),
        .cpl_i      (r_q.cpl),
        .v86_i      (r_q.v86),
        .fault_o    (perm_fault),
        .code_o     (perm_code)
    );

    // Memory port: one access per walk state, held until the response
    always_comb begin
        mem_req_valid_o = 1'b0;
        mem_req_write_o = 1'b0;
        mem_req_addr_o  = dir_addr;
        mem_req_wdata_o = '0;
        unique case (r_q.st)
            ST_RD_DIR: mem_req_valid_o = 1'b1;
            ST_WB_DIR: begin
                mem_req_valid_o = 1'b1;
                mem_req_write_o = 1'b1;
                mem_req_wdata_o = r_q.dir | acc_mask;
            end
            ST_RD_TBL: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = tbl_addr;
            end
            ST_WB_TBL: begin
                mem_req_valid_o = 1'b1;
                mem_req_write_o = 1'b1;
                mem_req_addr_o  = tbl_addr;
                mem_req_wdata_o = r_q.tbl;
            end
            default: ;
        endcase
    end

    // Which state ends the walk this cycle and with what entry
    always_comb begin
        fin_go     = 1'b0;
        fin_bypass = 1'b0;
        fin_hit    = 1'b0;
        fin_fill   = 1'b0;
        fin_entry  = '0;
        unique case (r_q.st)
            ST_LOOK: begin
                if (!r_q.pg) begin
                    fin_go     = 1'b1;
                    fin_bypass = 1'b1;
                end else if (tlb_hit) begin
                    fin_go    = 1'b1;
                    fin_hit   = 1'b1;
                    fin_entry = tlb_entry;
                end
            end
            ST_RD_DIR: begin
                if (mem_resp_valid_i && !mem_resp_rdata_i[BIT_P]) fin_go = 1'b1;
            end
            ST_RD_TBL: begin
                if (mem_resp_valid_i) begin
                    if (!mem_resp_rdata_i[BIT_P]) begin
                        fin_go = 1'b1;
                    end else if (mem_resp_rdata_i[BIT_ACC]) begin
                        fin_go    = 1'b1;
                        fin_fill  = 1'b1;
                        fin_entry = merge_perm(mem_resp_rdata_i | dirty_mask, r_q.dir);
                    end
                end
            end
            ST_WB_TBL: begin
                if (mem_resp_valid_i) begin
                    fin_go    = 1'b1;
                    fin_fill  = 1'b1;
                    fin_entry = merge_perm(r_q.tbl, r_q.dir);
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.lin = req_lin_i;
                    r_d.wr  = req_write_i;
                    r_d.wp  = wprot_en_i;
                    r_d.pg  = paging_en_i;
                    r_d.cpl = cpl_i;
                    r_d.v86 = v86_i;
                    r_d.st  = ST_LOOK;
                end
            end
            ST_LOOK:   r_d.st = ST_RD_DIR;
            ST_RD_DIR: begin
                if (mem_resp_valid_i) begin
                    r_d.dir = mem_resp_rdata_i;
                    r_d.st  = mem_resp_rdata_i[BIT_ACC] ? ST_RD_TBL : ST_WB_DIR;
                end
            end
            ST_WB_DIR: begin
                if (mem_resp_valid_i) r_d.st = ST_RD_TBL;
            end
            ST_RD_TBL: begin
                if (mem_resp_valid_i) begin
                    r_d.tbl = mem_resp_rdata_i | dirty_mask | acc_mask;
                    r_d.st  = ST_WB_TBL;
                end
            end
            default: ;
        endcase
        if (fin_go) begin
            r_d.st    = ST_IDLE;
            r_d.done  = 1'b1;
            r_d.entry = fin_entry;
            r_d.phys  = fin_bypass ? r_q.lin : {fin_entry[31:12], r_q.lin[11:0]};
            r_d.fault = perm_fault && !fin_bypass;
            r_d.code  = fin_bypass ? 3'd0 : perm_code;
            r_d.hit   = fin_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o  = (r_q.st == ST_IDLE);
    assign done_o       = r_q.done;
    assign entry_o      = r_q.entry;
    assign phys_o       = r_q.phys;
    assign fault_o      = r_q.fault && r_q.done;
    assign fault_code_o = r_q.code;
    assign hit_o        = r_q.hit;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_valid_o);

    assert_wb_accessed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_write_o) |-> mem_req_wdata_o[BIT_ACC]);

    assert_wp_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && entry_o[BIT_P] && r_q.wr && r_q.wp) |-> entry_o[BIT_RW]);

    assert_user_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && entry_o[BIT_P] && (r_q.v86 || r_q.cpl != 2'd0))
        |-> entry_o[BIT_US]);

    assert_bypass_phys_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !r_q.pg) |-> (phys_o == r_q.lin && !fault_o));

endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic [31:0] cr3 = 32'h0000_0000;
    logic        pg = 1'b1;
    logic        wp = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        v86 = 1'b0;
    logic        flush = 1'b0;
    logic        mreq, mwr;
    logic [31:0] maddr, mwdata;
    logic        mresp = 1'b0;
    logic [31:0] mrdata = '0;
    logic        done, fault, hit;
    logic [31:0] entry, phys;
    logic [2:0]  fcode;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] first_rd;
    logic [31:0] mem [0:2047];

    logic [31:0] r_entry, r_phys;
    logic        r_fault, r_hit;
    logic [2:0]  r_code;

    always #5 clk = ~clk;

    page_walker u_page_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_lin_i(req_lin), .req_write_i(req_write),
        .cr3_i(cr3), .paging_en_i(pg), .wprot_en_i(wp), .cpl_i(cpl), .v86_i(v86),
        .flush_i(flush),
        .mem_req_valid_o(mreq), .mem_req_write_o(mwr),
        .mem_req_addr_o(maddr), .mem_req_wdata_o(mwdata),
        .mem_resp_valid_i(mresp), .mem_resp_rdata_i(mrdata),
        .done_o(done), .entry_o(entry), .phys_o(phys),
        .fault_o(fault), .fault_code_o(fcode), .hit_o(hit)
    );

    // Memory model: answers each request within the same cycle
    always @(negedge clk) begin
        if (mreq) begin
            mresp  = 1'b1;
            mrdata = mem[maddr[12:2]];
            if (mwr) begin
                mem[maddr[12:2]] = mwdata;
                wr_cnt++;
            end else begin
                if (rd_cnt == 0) first_rd = maddr;
                rd_cnt++;
            end
        end else begin
            mresp = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 run timeout act 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] lin, input logic wr);
        bit got = 0;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        req_valid = 1'b1; req_lin = lin; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check("R11 done seen", 32'(got), 32'd1);
        r_entry = entry; r_phys = phys; r_fault = fault; r_hit = hit; r_code = fcode;
        @(negedge clk);
        check("R11 done pulse", 32'(done), 32'd0);
    endtask

    task automatic t_reset;
        check("R11 reset ready", 32'(req_ready), 32'd1);
        check("R11 reset done", 32'(done), 32'd0);
        check("R11 reset mem idle", 32'(mreq), 32'd0);
    endtask

    task automatic t_bypass;
        pg = 1'b0;
        access(32'hDEAD_BEEF, 1'b1);
        check("R10 phys", r_phys, 32'hDEAD_BEEF);
        check("R10 entry", r_entry, 32'd0);
        check("R10 fault", 32'(r_fault), 32'd0);
        check("R10 no mem", 32'(rd_cnt + wr_cnt), 32'd0);
        pg = 1'b1;
    endtask

    task automatic t_cold_walk;
        access(32'h0040_1123, 1'b0);
        check("R2 dir addr", first_rd, 32'h0000_0004);
        check("R3 R4 reads", 32'(rd_cnt), 32'd2);
        check("R3 R5 writes", 32'(wr_cnt), 32'd2);
        check("R3 dir updated", mem[1], 32'h0000_1027);
        check("R5 tbl updated", mem[11'h401], 32'h0005_5027);
        check("R6 entry", r_entry, 32'h0005_5027);
        check("R6 phys", r_phys, 32'h0005_5123);
        check("R1 first is miss", 32'(r_hit), 32'd0);
    endtask

    task automatic t_hit;
        access(32'h0040_1ABC, 1'b0);
        check("R1 hit", 32'(r_hit), 32'd1);
        check("R1 no mem", 32'(rd_cnt + wr_cnt), 32'd0);
        check("R1 entry", r_entry, 32'h0005_5027);
        check("R6 phys on hit", r_phys, 32'h0005_5ABC);
    endtask

    task automatic t_write_dirty;
        access(32'h0080_2000, 1'b1);
        check("R5 dirty entry", r_entry, 32'h0006_6067);
        check("R5 no writeback", 32'(wr_cnt), 32'd0);
        check("R5 mem unchanged", mem[11'h402], 32'h0006_6027);
        check("R7 no fault", 32'(r_fault), 32'd0);
    endtask

    task automatic t_not_present;
        access(32'h00C0_3000, 1'b0);
        check("R2 entry zero", r_entry, 32'd0);
        check("R2 fault", 32'(r_fault), 32'd1);
        check("R2 one read", 32'(rd_cnt), 32'd1);
        check("R7 code", 32'(r_code), 32'd0);
        access(32'h0100_4000, 1'b0);
        check("R4 entry zero", r_entry, 32'd0);
        check("R4 fault", 32'(r_fault), 32'd1);
        check("R4 two reads", 32'(rd_cnt), 32'd2);
        check("R4 tbl addr via data", 32'(wr_cnt), 32'd0);
    endtask

    task automatic t_wprot;
        cpl = 2'd3; wp = 1'b1;
        access(32'h0140_5000, 1'b0);
        check("R6 rw merged", r_entry, 32'h0008_8025);
        check("R7 read ok", 32'(r_fault), 32'd0);
        access(32'h0140_5000, 1'b1);
        check("R7 wp fault", 32'(r_fault), 32'd1);
        check("R7 wp code", 32'(r_code), 32'd5);
        wp = 1'b0;
        access(32'h0140_5000, 1'b1);
        check("R7 wp off", 32'(r_fault), 32'd0);
        cpl = 2'd0;
    endtask

    task automatic t_user;
        cpl = 2'd3;
        access(32'h0180_6000, 1'b0);
        check("R6 us merged", r_entry, 32'h0009_9023);
        check("R7 user fault", 32'(r_fault), 32'd1);
        check("R7 user code", 32'(r_code), 32'd3);
        cpl = 2'd0;
        access(32'h0180_6000, 1'b0);
        check("R7 supervisor ok", 32'(r_fault), 32'd0);
        v86 = 1'b1;
        access(32'h0180_6000, 1'b0);
        check("R8 v86 fault", 32'(r_fault), 32'd1);
        v86 = 1'b0;
    endtask

    task automatic t_all_ones;
        access(32'h01C0_9000, 1'b0);
        check("R9 ones entry", r_entry, 32'hFFFF_FFFF);
        access(32'h01C0_9000, 1'b0);
        check("R9 ones rewalk", 32'(rd_cnt), 32'd2);
        check("R9 ones no hit", 32'(r_hit), 32'd0);
    endtask

    task automatic t_flush;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        access(32'h0040_1123, 1'b0);
        check("R9 flush miss", 32'(r_hit), 32'd0);
        check("R9 flush reads", 32'(rd_cnt), 32'd2);
        check("R3 no second writeback", 32'(wr_cnt), 32'd0);
        check("R9 flush entry", r_entry, 32'h0005_5027);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        mem[1]      = 32'h0000_1007;  mem[11'h401] = 32'h0005_5007;
        mem[2]      = 32'h0000_1027;  mem[11'h402] = 32'h0006_6027;
        mem[3]      = 32'h0000_0000;
        mem[4]      = 32'h0000_1027;  mem[11'h404] = 32'h0007_7026;
        mem[5]      = 32'h0000_1025;  mem[11'h405] = 32'h0008_8027;
        mem[6]      = 32'h0000_1023;  mem[11'h406] = 32'h0009_9027;
        mem[7]      = 32'hFFFF_FFFF;  mem[11'h409] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_cold_walk();
        t_hit();
        t_write_dirty();
        t_not_present();
        t_wprot();
        t_user();
        t_all_ones();
        t_flush();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule